// File: doc/BRIEF.md
# Software Store Unlock Sequence Detector

This block observes the completed accesses of a 2048-byte memory. Each access arrives as a single-cycle strobe carrying an 11-bit address and a write flag. The block watches for an exact ordered chain of six reads: 0x000, then 0x555, 0x2AA, 0x7FF, 0x0F0 and finally 0x70F. When it sees that chain, it emits a one-cycle store request to the store/recall controller.

Any other access between two links of the chain aborts it. That includes a write, even one to the expected address. The detector only observes the access stream. Reads that form the chain still return ordinary memory data, and the output-enable level plays no part. While the controller reports busy, the detector ignores all traffic and stays idle.

Top module: `sw_store_unlock`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `store_req` is low and the detector is idle, with no steps of the chain matched.
- R2: Six strobed reads from 0x000, 0x555, 0x2AA, 0x7FF, 0x0F0 and 0x70F, in that order, drive `store_req` high in the cycle after the strobe of the sixth read.
- R3: `store_req` is high for exactly one cycle per completed chain. The detector then returns to idle, so a second request needs a full new chain.
- R4: A strobed write (`acc_wr`=1) at any point aborts the chain, even when it targets the expected address, and never produces a request.
- R5: A strobed read from an address other than the next expected one aborts the chain.
- R6: When an aborting access is a read of 0x000, the chain restarts with that read counted as step 1, so five further correct reads complete it. Any other aborting access returns the detector to idle.
- R7: While `ctrl_busy` is high, strobes are ignored, no request is raised and the detector is forced to idle.
- R8: Cycles without a strobe leave the chain progress unchanged, so idle gaps between links are allowed.
- R9: Matching uses all 11 address bits. An address that differs from the expected one in any bit, such as 0x455 in place of 0x555, aborts the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_stb | input | 1 | One-cycle strobe marking a completed access |
| acc_addr | input | 11 | Address of the access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| ctrl_busy | input | 1 | Store/recall controller busy; detector ignores traffic |
| store_req | output | 1 | One-cycle store request |

## Verification
The only result is `store_req`. It is registered, so it is due exactly one clock after the edge that samples the strobe of the sixth read. The bench drives each access on a falling edge and compares `store_req` on the following falling edge against a requirement-level model updated with that same access. This places every comparison one rising edge after its stimulus. Idle, write and busy cycles are checked the same way, so a spurious or late pulse is caught in the cycle it appears.

// File: rtl/sw_store_unlock.sv
module sw_store_unlock (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_stb,
  input  logic [10:0] acc_addr,
  input  logic        acc_wr,
  input  logic        ctrl_busy,
  output logic        store_req
);
  localparam int SEQ_LEN = 6;
  localparam int SW      = $clog2(SEQ_LEN);

  logic [SW-1:0] step_q, step_d;
  logic          req_d;

  function automatic logic [10:0] key_at(input logic [SW-1:0] i);
    case (i)
      SW'(0):  return 11'h000;
      SW'(1):  return 11'h555;
      SW'(2):  return 11'h2AA;
      SW'(3):  return 11'h7FF;
      SW'(4):  return 11'h0F0;
      SW'(5):  return 11'h70F;
      default: return 11'h000;
    endcase
  endfunction

  wire is_rd   = acc_stb && !acc_wr;
  wire hit     = is_rd && (acc_addr == key_at(step_q));
  wire last    = (step_q == SW'(SEQ_LEN-1));
  wire restart = is_rd && (acc_addr == key_at('0));

  always_comb begin
    step_d = step_q;
    req_d  = 1'b0;
    if (ctrl_busy) begin
      step_d = '0;
    end else if (acc_stb) begin
      if (hit) begin
        if (last) begin
          step_d = '0;
          req_d  = 1'b1;
        end else begin
          step_d = step_q + SW'(1);
        end
      end else if (restart) begin
        step_d = SW'(1);
      end else begin
        step_d = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q    <= '0;
      store_req <= 1'b0;
    end else begin
      step_q    <= step_d;
      store_req <= req_d;
    end
  end
endmodule

// File: rtl/sw_store_unlock_chk.sv
module sw_store_unlock_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_stb,
  input logic [10:0] acc_addr,
  input logic        acc_wr,
  input logic        ctrl_busy,
  input logic        store_req,
  input logic [2:0]  step_q
);
  a_r2_req_follows_last_read: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |-> $past(acc_stb && !acc_wr && !ctrl_busy && acc_addr == 11'h70F));

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |=> !store_req);

  a_r4_write_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && acc_wr) |=> !store_req);

  a_r7_busy_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_busy |=> (!store_req && step_q == 3'd0));

  a_r8_gap_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_stb && !ctrl_busy) |=> $stable(step_q));

  a_r6_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= 3'd5);
endmodule

bind sw_store_unlock sw_store_unlock_chk u_chk (.*);

// File: tb/test_sw_store_unlock.sv
module test_sw_store_unlock;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_stb;
  logic [10:0] acc_addr;
  logic        acc_wr;
  logic        ctrl_busy;
  logic        store_req;

  int n_cmp = 0;
  int n_bad = 0;
  int ms    = 0;
  bit done  = 1'b0;

  localparam logic [10:0] KEYS [6] = '{11'h000, 11'h555, 11'h2AA, 11'h7FF, 11'h0F0, 11'h70F};

  always #4 clk = ~clk;

  sw_store_unlock i_sw_store_unlock (.*);

  task automatic check(input bit act, input bit exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: store_req=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit model(input bit v, input logic [10:0] a, input bit w, input bit b);
    bit r = 1'b0;
    if (b) ms = 0;
    else if (v) begin
      if (!w && a == KEYS[ms]) begin
        if (ms == 5) begin r = 1'b1; ms = 0; end
        else ms++;
      end else if (!w && a == 11'h000) ms = 1;
      else ms = 0;
    end
    return r;
  endfunction

  task automatic cyc(input bit v, input logic [10:0] a, input bit w, input bit b, input string tag);
    bit e;
    acc_stb = v; acc_addr = a; acc_wr = w; ctrl_busy = b;
    e = model(v, a, w, b);
    @(negedge clk);
    check(store_req, e, tag);
  endtask

  task automatic rd(input logic [10:0] a, input string tag);
    cyc(1'b1, a, 1'b0, 1'b0, tag);
  endtask

  task automatic chain(input int from, input int upto, input string tag);
    for (int i = from; i <= upto; i++) rd(KEYS[i], tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; acc_stb = 1'b0; acc_addr = '0; acc_wr = 1'b0; ctrl_busy = 1'b0;
    @(negedge clk);
    check(store_req, 1'b0, "R1 reset");
    rd(11'h000, "R1 held in reset");
    @(negedge clk);
    check(store_req, 1'b0, "R1 reset");
    rst_n = 1'b1;
    ms = 0;
    cyc(1'b0, 11'h000, 1'b0, 1'b0, "R1 after reset");
    chain(0, 5, "R2 full chain");
    cyc(1'b0, 11'h000, 1'b0, 1'b0, "R3 pulse ends");
    rd(11'h70F, "R3 no repeat");
    chain(0, 2, "R8 gaps");
    repeat (3) cyc(1'b0, 11'h123, 1'b0, 1'b0, "R8 gaps");
    chain(3, 5, "R8 gaps complete");
    chain(0, 2, "R4 pre");
    cyc(1'b1, 11'h7FF, 1'b1, 1'b0, "R4 write aborts");
    chain(3, 5, "R4 no request");
    chain(0, 3, "R5 pre");
    rd(11'h123, "R5 wrong read");
    rd(11'h0F0, "R5 no resume");
    rd(11'h70F, "R5 no request");
    chain(0, 3, "R6 pre");
    rd(11'h000, "R6 restart");
    chain(1, 5, "R6 completes");
    chain(0, 4, "R7 pre");
    cyc(1'b1, 11'h70F, 1'b0, 1'b1, "R7 busy ignores");
    rd(11'h70F, "R7 reset to idle");
    cyc(1'b1, 11'h000, 1'b0, 1'b1, "R7 busy");
    chain(0, 5, "R7 after busy");
    rd(11'h000, "R9 pre");
    rd(11'h455, "R9 near miss");
    chain(2, 5, "R9 no request");
    for (int n = 0; n < 4000; n++) begin
      int k = $urandom_range(0, 99);
      logic [10:0] a = (k < 70) ? KEYS[(k < 55) ? ms : $urandom_range(0, 5)] : 11'($urandom);
      cyc($urandom_range(0, 9) < 8, a, $urandom_range(0, 19) == 0,
          $urandom_range(0, 39) == 0, "R2 random");
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule